// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar in packed BCD registers: seconds, minutes, hours, date, month, day-of-week and a two-digit year. A reference enable that pulses at 32.768 kHz feeds a binary prescaler, and the prescaler produces one advance per second. The hours register holds its own format. Bit 7 of hours picks a 12-hour or a 24-hour count. Bit 5 of hours is the PM flag in 12-hour form and the tens digit for 20 to 23 in 24-hour form.

A parallel load port writes any one register in a clock cycle. A load to the seconds register also clears the prescaler, so the next advance comes one full second after the load. The day-of-week is a free counter from 1 to 7 that steps at midnight. The date rolls over at the real month length. February has 29 days when the year is divisible by 4, and this rule covers years 00 to 99. Loaded values that are not BCD or are out of range give undefined results.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00 (24-hour form), date 01, month 01, day-of-week 1 and year 00, and `tick_o` is low.
- R2: Seconds and minutes count 00 to 59 in BCD. A seconds wrap from 59 to 00 advances minutes, and a minutes wrap advances hours.
- R3: With hours bit 7 = 0, hours count 00 to 23. Bit 5 is the tens digit 2, and the step from 23 to 00 starts a new day.
- R4: With hours bit 7 = 1, the hour digits (bits 4:0) count 12, 01, ..., 11. Bit 5 (1 = PM) flips when 11:59:59 becomes 12:00:00, and the step from 11:59:59 PM starts a new day.
- R5: The day-of-week counts 1 to 7 and changes only at the start of a new day, stepping from 7 back to 1.
- R6: The date counts from 01 up to the month length (30 for months 04, 06, 09, 11; 31 for the others except 02) and then returns to 01 while the month advances.
- R7: In month 02 the last date is 29 when the BCD year is divisible by 4 and 28 otherwise.
- R8: The month counts 01 to 12, and the step from 12 back to 01 advances the year. The year counts 00 to 99 and wraps to 00.
- R9: `tick_o` is high for one clock in each 2^DIV_BITS cycles in which `ref_pulse` is high and `ld_en` is low, and the registers advance one second at that edge. Cycles with `ref_pulse` low do not count.
- R10: A load with `ld_sel` = 0 clears the prescaler, so the next advance comes after exactly 2^DIV_BITS further counted reference pulses.
- R11: When `ld_en` is high, `ld_data` is written to the register that `ld_sel` names (0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day-of-week, 6 year). Code 7 writes nothing. No register advances and the prescaler holds in a load cycle. Hours bit 7 changes only by a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Register select for a load |
| ld_data | input | 8 | BCD value to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours: bit 7 mode, bit 5 PM or tens digit 2, BCD digits below |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| wday_o | output | 8 | Day-of-week, 1 to 7 |
| year_o | output | 8 | Year, BCD |
| tick_o | output | 1 | One-second advance event |

## Verification
The bench sets the prescaler to 2 bits, so one second lasts four clocks. It then compares every register against a binary-integer calendar model after each second. A continuous run of more than an hour from midnight covers every seconds and minutes value and the carries between them. All 24 hours are started at hh:59:58 in both hour formats, which separates the 12-hour sequence, the PM flip and the midnight day change from the 24-hour count. The last day of every month is crossed in each of the 100 years, and February 28 is crossed in each year, which separates leap from common years and month-end from year-end. Separate patterns gate the reference pulses, reload the seconds in mid-second to show that the prescaler clears, and issue a load with the unused select code.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DATE  = 3'd3,
    SEL_MONTH = 3'd4,
    SEL_WDAY  = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_NONE  = 3'd7
  } rtc_sel_e;

  typedef struct packed {
    logic [7:0] val;
    logic       wrap;
  } step_t;

  // add one to a two-digit packed BCD value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by four: even tens need ones 0/4/8, odd tens need ones 2/6
  function automatic logic leap_bcd(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // counter that returns to 'first' after 'last'
  function automatic step_t wrap_step(input logic [7:0] v, input logic [7:0] last,
                                      input logic [7:0] first);
    step_t r;
    if (v == last) begin
      r.val  = first;
      r.wrap = 1'b1;
    end else begin
      r.val  = bcd_inc(v);
      r.wrap = 1'b0;
    end
    return r;
  endfunction

  // hours advance in either format; wrap marks the start of a new day
  function automatic step_t hour_step(input logic [7:0] h);
    step_t      r;
    logic [7:0] t;
    r.wrap = 1'b0;
    if (h[7]) begin
      t = bcd_inc({3'b000, h[4:0]});
      if (h[4:0] == 5'h11) begin
        r.val  = {h[7:6], ~h[5], 5'h12};
        r.wrap = h[5];
      end else if (h[4:0] == 5'h12) begin
        r.val = {h[7:5], 5'h01};
      end else begin
        r.val = {h[7:5], t[4:0]};
      end
    end else begin
      t = bcd_inc({2'b00, h[5:0]});
      if (h[5:0] == 6'h23) begin
        r.val  = {h[7:6], 6'h00};
        r.wrap = 1'b1;
      end else begin
        r.val = {h[7:6], t[5:0]};
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic hold,
  input  logic clr,
  output logic tick
);
  localparam logic [DIV_BITS-1:0] CNT_MAX = {DIV_BITS{1'b1}};

  logic [DIV_BITS-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (ref_pulse && !hold) cnt <= cnt + 1'b1;
  end

  assign tick = ref_pulse && !hold && (cnt == CNT_MAX);
endmodule

// File: rtl/rtc_time.sv
module rtc_time
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ld_en,
  input  rtc_sel_e   ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic       sec_wrap,
  output logic       min_wrap,
  output logic       day_carry
);
  step_t s_n, m_n, h_n;

  always_comb begin
    s_n = wrap_step(sec, 8'h59, 8'h00);
    m_n = wrap_step(min, 8'h59, 8'h00);
    h_n = hour_step(hour);
  end

  assign sec_wrap  = tick && s_n.wrap;
  assign min_wrap  = sec_wrap && m_n.wrap;
  assign day_carry = min_wrap && h_n.wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= 8'h00;
    end else if (ld_en) begin
      case (ld_sel)
        SEL_SEC:  sec  <= ld_data;
        SEL_MIN:  min  <= ld_data;
        SEL_HOUR: hour <= ld_data;
        default: ;
      endcase
    end else if (tick) begin
      sec <= s_n.val;
      if (sec_wrap) min  <= m_n.val;
      if (min_wrap) hour <= h_n.val;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry,
  input  logic       ld_en,
  input  rtc_sel_e   ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] wday,
  output logic [7:0] year,
  output logic       mon_wrap,
  output logic       year_wrap
);
  step_t d_n, mo_n, y_n, w_n;

  always_comb begin
    d_n  = wrap_step(date, month_last(month, year), 8'h01);
    mo_n = wrap_step(month, 8'h12, 8'h01);
    y_n  = wrap_step(year, 8'h99, 8'h00);
    w_n  = wrap_step(wday, 8'h07, 8'h01);
  end

  logic date_wrap;
  assign date_wrap = day_carry && d_n.wrap;
  assign mon_wrap  = date_wrap && mo_n.wrap;
  assign year_wrap = mon_wrap && y_n.wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date  <= 8'h01;
      month <= 8'h01;
      wday  <= 8'h01;
      year  <= 8'h00;
    end else if (ld_en) begin
      case (ld_sel)
        SEL_DATE:  date  <= ld_data;
        SEL_MONTH: month <= ld_data;
        SEL_WDAY:  wday  <= ld_data;
        SEL_YEAR:  year  <= ld_data;
        default: ;
      endcase
    end else if (day_carry) begin
      wday <= w_n.val;
      date <= d_n.val;
      if (date_wrap) month <= mo_n.val;
      if (mon_wrap)  year  <= y_n.val;
    end
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pulse,
  input  logic       ld_en,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] wday_o,
  output logic [7:0] year_o,
  output logic       tick_o
);
  rtc_sel_e sel_e;
  logic     div_clr;
  logic     sec_wrap, min_wrap, day_carry, mon_wrap, year_wrap;

  assign sel_e   = rtc_sel_e'(ld_sel);
  assign div_clr = ld_en && (sel_e == SEL_SEC);

  rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_div (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse),
    .hold(ld_en), .clr(div_clr), .tick(tick_o)
  );

  rtc_time u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick_o),
    .ld_en(ld_en), .ld_sel(sel_e), .ld_data(ld_data),
    .sec(sec_o), .min(min_o), .hour(hour_o),
    .sec_wrap(sec_wrap), .min_wrap(min_wrap), .day_carry(day_carry)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .day_carry(day_carry),
    .ld_en(ld_en), .ld_sel(sel_e), .ld_data(ld_data),
    .date(date_o), .month(month_o), .wday(wday_o), .year(year_o),
    .mon_wrap(mon_wrap), .year_wrap(year_wrap)
  );
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_en,
  input logic [2:0] ld_sel,
  input logic       tick,
  input logic       sec_wrap,
  input logic       min_wrap,
  input logic       day_carry,
  input logic       mon_wrap,
  input logic       year_wrap,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] wday,
  input logic [7:0] year
);
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> (sec == 8'h00) && (min != $past(min))); // R2
  AST_MIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    min_wrap |=> (min == 8'h00)); // R2
  AST_24H_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !hour[7] |-> (hour[5:0] <= 6'h23)); // R3
  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && hour[7] && hour[4:0] == 5'h11) |=> (hour[5] != $past(hour[5])) && (hour[4:0] == 5'h12)); // R4
  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wday >= 8'h01) && (wday <= 8'h07)); // R5
  AST_WDAY_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> (wday != $past(wday))); // R5
  AST_MON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mon_wrap |=> (month == 8'h01) && (year != $past(year))); // R8
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap |=> (year == 8'h00)); // R8
  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel == 3'd0) |=> !tick); // R10
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_en) |=> $stable(sec) && $stable(min) && $stable(hour) && $stable(date)
                          && $stable(month) && $stable(wday) && $stable(year)); // R11
  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_en && ld_sel == 3'd2) |=> (hour[7] == $past(hour[7]))); // R11
endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .tick(tick_o),
  .sec_wrap(sec_wrap), .min_wrap(min_wrap), .day_carry(day_carry),
  .mon_wrap(mon_wrap), .year_wrap(year_wrap),
  .sec(sec_o), .min(min_o), .hour(hour_o), .date(date_o),
  .month(month_o), .wday(wday_o), .year(year_o)
);

// File: tb/bcd_rtc_tb.sv
`timescale 1ns/1ps
module bcd_rtc_tb;
  localparam int DIVB = 2;
  localparam int SPS  = 1 << DIVB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_pulse = 1'b0;
  logic       ld_en = 1'b0;
  logic [2:0] ld_sel = 3'd7;
  logic [7:0] ld_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o;
  logic       tick_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // binary model state
  int m_s, m_m, m_h, m_dt, m_mo, m_yr, m_wd, m_12;

  always #2.5 clk = ~clk;

  bcd_rtc #(.DIV_BITS(DIVB)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .ld_en(ld_en),
    .ld_sel(ld_sel), .ld_data(ld_data), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .date_o(date_o), .month_o(month_o), .wday_o(wday_o),
    .year_o(year_o), .tick_o(tick_o)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_reg(input int mode12, input int hh);
    int         h12;
    logic [7:0] b;
    if (mode12 == 0) return to_bcd(hh);
    h12 = hh % 12;
    if (h12 == 0) h12 = 12;
    b = to_bcd(h12);
    return {1'b1, 1'b0, (hh >= 12), b[4:0]};
  endfunction

  function automatic logic [55:0] model_vec();
    return {to_bcd(m_s), to_bcd(m_m), hour_reg(m_12, m_h), to_bcd(m_dt),
            to_bcd(m_mo), to_bcd(m_wd), to_bcd(m_yr)};
  endfunction

  function automatic logic [55:0] dut_vec();
    return {sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o};
  endfunction

  task automatic model_step();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_m++;
      if (m_m == 60) begin
        m_m = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_wd = (m_wd % 7) + 1;
          m_dt++;
          if (m_dt > mdays(m_mo, m_yr)) begin
            m_dt = 1; m_mo++;
            if (m_mo == 13) begin
              m_mo = 1;
              m_yr = (m_yr + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic chk_all(input string req);
    n_chk++;
    if (dut_vec() !== model_vec()) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, dut_vec(), model_vec());
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic put(input int sel, input logic [7:0] d);
    ld_sel  = 3'(sel);
    ld_data = d;
    @(negedge clk);
  endtask

  // loads all registers, seconds last, so the prescaler restarts at zero
  task automatic set_time(input int md, input int hh, input int mm, input int ss,
                          input int dt, input int mo, input int yr, input int wd);
    m_12 = md; m_h = hh; m_m = mm; m_s = ss;
    m_dt = dt; m_mo = mo; m_yr = yr; m_wd = wd;
    @(negedge clk);
    ld_en = 1'b1;
    put(6, to_bcd(yr));
    put(4, to_bcd(mo));
    put(3, to_bcd(dt));
    put(5, to_bcd(wd));
    put(2, hour_reg(md, hh));
    put(1, to_bcd(mm));
    put(0, to_bcd(ss));
    ld_en = 1'b0;
    ld_sel = 3'd7;
  endtask

  task automatic run_secs(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      repeat (SPS) @(negedge clk);
      model_step();
      chk_all(req);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    m_s = 0; m_m = 0; m_h = 0; m_12 = 0; m_dt = 1; m_mo = 1; m_wd = 1; m_yr = 0;
    chk_all("R1");
    chk_bit("R1 tick", tick_o, 1'b0);
    ref_pulse = 1'b1;

    // R2 R3: continuous run from midnight, past the first hour
    set_time(0, 0, 0, 0, 10, 3, 21, 2);
    run_secs(3665, "R2");

    // R3 R4 R5: every hour in both formats across its top-of-hour
    for (int md = 0; md < 2; md++)
      for (int hh = 0; hh < 24; hh++) begin
        set_time(md, hh, 59, 58, 15, 6, 24, (hh % 7) + 1);
        run_secs(3, md ? "R4" : "R3");
      end
    set_time(0, 23, 59, 59, 20, 7, 30, 7);
    run_secs(1, "R5 wday 7->1");
    set_time(1, 23, 59, 59, 20, 7, 30, 7);
    run_secs(1, "R5 12h midnight");

    // R6 R7 R8: last day of every month in every year
    for (int mo = 1; mo <= 12; mo++)
      for (int yr = 0; yr < 100; yr++) begin
        set_time(0, 23, 59, 59, mdays(mo, yr), mo, yr, 4);
        run_secs(1, (mo == 2) ? "R7" : ((mo == 12) ? "R8" : "R6"));
      end
    for (int yr = 0; yr < 100; yr++) begin
      set_time(0, 23, 59, 59, 28, 2, yr, 1);
      run_secs(1, "R7 feb28");
    end

    // R9: gated reference pulses
    set_time(0, 8, 30, 10, 5, 5, 55, 3);
    ref_pulse = 1'b0;
    repeat (20) @(negedge clk);
    chk_all("R9 no ref");
    chk_bit("R9 no tick", tick_o, 1'b0);
    ref_pulse = 1'b1;
    repeat (SPS - 2) @(negedge clk);
    chk_bit("R9 tick low", tick_o, 1'b0);
    @(negedge clk);
    chk_bit("R9 tick high", tick_o, 1'b1);
    @(negedge clk);
    model_step();
    chk_all("R9 advance");

    // R10: mid-second reload of seconds restarts the full second
    set_time(0, 9, 0, 0, 5, 5, 55, 3);
    repeat (SPS - 2) @(negedge clk);
    ld_en = 1'b1; ld_sel = 3'd0; ld_data = 8'h40;
    @(negedge clk);
    ld_en = 1'b0; ld_sel = 3'd7;
    m_s = 40;
    chk_all("R10 load");
    repeat (SPS - 2) @(negedge clk);
    chk_bit("R10 tick low", tick_o, 1'b0);
    @(negedge clk);
    chk_bit("R10 tick high", tick_o, 1'b1);
    @(negedge clk);
    model_step();
    chk_all("R10 advance");

    // R11: unused select code writes nothing; single register load
    set_time(1, 14, 22, 33, 9, 11, 12, 6);
    ld_en = 1'b1; ld_sel = 3'd7; ld_data = 8'h55;
    @(negedge clk);
    ld_en = 1'b0;
    chk_all("R11 sel7");
    ld_en = 1'b1; ld_sel = 3'd1; ld_data = 8'h42;
    @(negedge clk);
    ld_en = 1'b0; ld_sel = 3'd7;
    m_m = 42;
    chk_all("R11 min load");
    chk_bit("R11 mode kept", hour_o[7], 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule